// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one logic cell of a programmable fabric. Two four-input lookup tables (the G table and the F table) each return the configuration bit selected by their four inputs. A three-input lookup table (the H table) combines the G result, the F result and one extra input. The G and F results leave the cell as the combinational outputs `yOut` and `xOut`.

Two storage flip-flops drive `xq` and `yq`. Each one takes its data from the G, F or H result, or from the direct data input `dIn`. Both flip-flops share a clock enable and a synchronous set/reset strobe. The value each flip-flop takes under set/reset comes from configuration, and so does the clock edge the flip-flops use.

All truth tables and selects sit in a configuration word of 47 bits. The word is loaded serially at start-up while `cfgLoad` is high. A typical use, such as a bit-serial adder, puts the sum function in one table and the carry function in another, and keeps the carry in a flip-flop fed back into the tables.

Top module: `lutCell`

## Requirements
- R1: `yOut` equals bit `gIn` (an index from 0 to 15) of the G table, with configuration bits [15:0] forming the G table.
- R2: `xOut` equals bit `fIn` of the F table, with configuration bits [31:16] forming the F table.
- R3: The H result equals bit {hIn, F result, G result} of the H table, with configuration bits [39:32] forming the H table and hIn as the index MSB.
- R4: The X flip-flop source select is configuration bits [41:40] and the Y select is bits [43:42]. Codes: 0 selects the G result, 1 the F result, 2 the H result, 3 `dIn`. With enable high, the selected value appears on `xq`/`yq` after the active clock edge.
- R5: With `ce` low and `sr` low, an active edge leaves `xq` and `yq` unchanged.
- R6: `sr` high at an active edge loads X with configuration bit 44 and Y with bit 45, whatever `ce` and the data are.
- R7: Configuration bit 46 equal to 0 makes the flip-flops update on the rising edge of `clk`; equal to 1 makes them update on the falling edge only.
- R8: While `cfgLoad` is high, each rising edge of `clk` shifts `cfgIn` into bit 0 of the configuration word, so the word is sent MSB first. During loading the flip-flops are held at 0. Asynchronous reset (`rstN` low) clears the configuration and both flip-flops.
- R9: With the G table set to the three-input parity function and the F table set to an enabled majority function, the cell performs bit-serial addition, with the carry held in the X flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Configuration shift enable |
| cfgIn | input | 1 | Serial configuration data |
| gIn | input | 4 | G table inputs |
| fIn | input | 4 | F table inputs |
| hIn | input | 1 | Extra H table input |
| dIn | input | 1 | Direct flip-flop data |
| ce | input | 1 | Shared clock enable |
| sr | input | 1 | Shared synchronous set/reset |
| xOut | output | 1 | F table result |
| yOut | output | 1 | G table result |
| xq | output | 1 | X flip-flop output |
| yq | output | 1 | Y flip-flop output |

## Verification
The bench uses the package defaults: four-input G and F tables, a three-input H table and two-bit source selects. The configuration word is therefore only 47 bits, so the bench can reload it between scenarios in a few dozen cycles. That covers every source code, both set/reset values, both clock polarities and a complete serial-adder setup, within short runs. Vector walks cover G, F and H addressing at several input patterns, and directed cases cover enable hold, set/reset priority and hold during loading.

// File: rtl/cellPkg.sv
package cellPkg;
  localparam int LUT_IN = 4;
  localparam int H_IN = 3;
  localparam int SEL_W = 2;
  localparam int LUT_BITS = 2 ** LUT_IN;
  localparam int H_BITS = 2 ** H_IN;

  localparam logic [SEL_W-1:0] SRC_G = 2'd0;
  localparam logic [SEL_W-1:0] SRC_F = 2'd1;
  localparam logic [SEL_W-1:0] SRC_H = 2'd2;
  localparam logic [SEL_W-1:0] SRC_D = 2'd3;

  // Packed MSB first: the field listed last occupies bit 0 upward.
  typedef struct packed {
    logic                negEdge;
    logic                ySrVal;
    logic                xSrVal;
    logic [SEL_W-1:0]    ySel;
    logic [SEL_W-1:0]    xSel;
    logic [H_BITS-1:0]   hTable;
    logic [LUT_BITS-1:0] fTable;
    logic [LUT_BITS-1:0] gTable;
  } cellCfg_t;

  localparam int CFG_BITS = $bits(cellCfg_t);

  typedef struct packed {
    logic hold;
    logic capture;
    logic setRst;
  } cellStrb_t;
endpackage

// File: rtl/cellLut.sv
module cellLut #(
  parameter int N = 4
) (
  input  logic [2**N-1:0] tbl,
  input  logic [N-1:0]    sel,
  output logic            o
);
  assign o = tbl[sel];
endmodule

// File: rtl/cellCtrl.sv
module cellCtrl
  import cellPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoad,
  input  logic      cfgIn,
  input  logic      ce,
  input  logic      sr,
  output cellCfg_t  cfg,
  output cellStrb_t strb
);
  logic [CFG_BITS-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftQ <= '0;
    else if (cfgLoad) shiftQ <= {shiftQ[CFG_BITS-2:0], cfgIn};
  end

  assign cfg = cellCfg_t'(shiftQ);

  always_comb begin
    strb.hold    = cfgLoad;
    strb.capture = ce & ~cfgLoad;
    strb.setRst  = sr & ~cfgLoad;
  end

  // R8: serial bit enters at position 0
  p_shift_in_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> shiftQ[0] == $past(cfgIn));
  // R8: configuration is frozen outside loading
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(shiftQ));
endmodule

// File: rtl/cellPath.sv
module cellPath
  import cellPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  cellCfg_t  cfg,
  input  cellStrb_t strb,
  input  logic [LUT_IN-1:0] gIn,
  input  logic [LUT_IN-1:0] fIn,
  input  logic      hIn,
  input  logic      dIn,
  output logic      xOut,
  output logic      yOut,
  output logic      xq,
  output logic      yq
);
  logic gRes, fRes, hRes;
  logic cellClk;
  logic [1:0][SEL_W-1:0] srcSel;
  logic [1:0] srVal;
  logic [1:0] q;

  cellLut #(.N(LUT_IN)) u_gLut (.tbl(cfg.gTable), .sel(gIn), .o(gRes));
  cellLut #(.N(LUT_IN)) u_fLut (.tbl(cfg.fTable), .sel(fIn), .o(fRes));
  cellLut #(.N(H_IN))   u_hLut (.tbl(cfg.hTable), .sel({hIn, fRes, gRes}), .o(hRes));

  // Polarity select: inverted clock makes the falling edge active.
  assign cellClk = clk ^ cfg.negEdge;
  assign srcSel  = {cfg.ySel, cfg.xSel};
  assign srVal   = {cfg.ySrVal, cfg.xSrVal};

  for (genvar i = 0; i < 2; i++) begin : g_ff
    logic dSel;
    always_comb begin
      case (srcSel[i])
        SRC_G:   dSel = gRes;
        SRC_F:   dSel = fRes;
        SRC_H:   dSel = hRes;
        default: dSel = dIn;
      endcase
    end

    always_ff @(posedge cellClk or negedge rstN) begin
      if (!rstN)            q[i] <= 1'b0;
      else if (strb.hold)   q[i] <= 1'b0;
      else if (strb.setRst) q[i] <= srVal[i];
      else if (strb.capture) q[i] <= dSel;
    end

    // R8: flip-flops cleared while configuration loads
    p_hold_clear_r8: assert property (@(posedge cellClk) disable iff (!rstN)
      strb.hold |=> !q[i]);
    // R6: set/reset wins and takes the configured value
    p_sr_value_r6: assert property (@(posedge cellClk) disable iff (!rstN)
      strb.setRst |=> q[i] == $past(srVal[i]));
    // R5: no enable, no change
    p_ce_hold_r5: assert property (@(posedge cellClk) disable iff (!rstN)
      (!strb.hold && !strb.setRst && !strb.capture) |=> $stable(q[i]));
    // R4: direct input path
    p_din_path_r4: assert property (@(posedge cellClk) disable iff (!rstN)
      (strb.capture && !strb.setRst && !strb.hold && srcSel[i] == SRC_D)
        |=> q[i] == $past(dIn));
  end

  assign xOut = fRes;
  assign yOut = gRes;
  assign xq   = q[0];
  assign yq   = q[1];
endmodule

// File: rtl/lutCell.sv
module lutCell
  import cellPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       cfgIn,
  input  logic [3:0] gIn,
  input  logic [3:0] fIn,
  input  logic       hIn,
  input  logic       dIn,
  input  logic       ce,
  input  logic       sr,
  output logic       xOut,
  output logic       yOut,
  output logic       xq,
  output logic       yq
);
  cellCfg_t  cfg;
  cellStrb_t strb;

  cellCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
    .ce(ce), .sr(sr), .cfg(cfg), .strb(strb)
  );

  cellPath u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb),
    .gIn(gIn), .fIn(fIn), .hIn(hIn), .dIn(dIn),
    .xOut(xOut), .yOut(yOut), .xq(xq), .yq(yq)
  );
endmodule

// File: tb/lutCell_tb.sv
module lutCell_tb;
  import cellPkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CG = 16'hA5C3;
  localparam logic [15:0] CF = 16'h6E19;
  localparam logic [7:0]  CH = 8'hB4;
  // fields: g[9:6] f[5:2] h[1] d[0]
  localparam logic [9:0] VEC [0:7] = '{
    10'b0000_0000_0_0, 10'b0101_1100_1_1, 10'b1111_1111_0_1, 10'b0011_0110_1_0,
    10'b1000_0001_1_1, 10'b1010_1011_0_0, 10'b0110_1001_1_1, 10'b1101_0010_0_1};

  logic clk = 0, rstN = 0, cfgLoad = 0, cfgIn = 0, hIn = 0, dIn = 0, ce = 0, sr = 0;
  logic [3:0] gIn = 0, fIn = 0;
  logic xOut, yOut, xq, yq;
  int nChecks = 0, nErrors = 0;

  lutCell u_dut (.clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
    .gIn(gIn), .fIn(fIn), .hIn(hIn), .dIn(dIn), .ce(ce), .sr(sr),
    .xOut(xOut), .yOut(yOut), .xq(xq), .yq(yq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadCfg(input cellCfg_t c);
    for (int i = CFG_BITS-1; i >= 0; i--) begin
      @(negedge clk); #2;
      cfgLoad = 1; cfgIn = c[i];
    end
    @(negedge clk); #2;
    cfgLoad = 0;
    chk("R8 xq held during load", xq, 0);
    chk("R8 yq held during load", yq, 0);
  endtask

  task automatic drive(input logic [3:0] g, input logic [3:0] f, input logic h, input logic d);
    @(negedge clk); #2;
    gIn = g; fIn = f; hIn = h; dIn = d;
  endtask

  task automatic afterRise;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    cellCfg_t c;
    logic [4:0] sum;
    repeat (3) @(negedge clk);
    #2 rstN = 1;
    #1;
    chk("R8 reset xq", xq, 0);
    chk("R8 reset yq", yq, 0);
    chk("R8 reset xOut", xOut, 0);

    // Vector walk: X takes H, Y takes dIn
    c = '0; c.gTable = CG; c.fTable = CF; c.hTable = CH; c.xSel = 2'd2; c.ySel = 2'd3;
    loadCfg(c);
    ce = 1;
    for (int v = 0; v < 8; v++) begin
      logic [3:0] g, f;
      logic h, d;
      {g, f, h, d} = VEC[v];
      drive(g, f, h, d);
      #1;
      chk("R1 yOut G table", yOut, CG[g]);
      chk("R2 xOut F table", xOut, CF[f]);
      afterRise();
      chk("R3 xq from H table", xq, CH[{h, CF[f], CG[g]}]);
      chk("R4 yq from dIn", yq, d);
    end

    // Other source codes; load also clears nonzero state
    c.xSel = 2'd0; c.ySel = 2'd1;
    loadCfg(c);
    drive(4'b0110, 4'b1100, 0, 0);
    afterRise();
    chk("R4 xq from G", xq, CG[6]);
    chk("R4 yq from F", yq, CF[12]);

    // Enable hold
    c.xSel = 2'd3; c.ySel = 2'd3;
    loadCfg(c);
    drive(0, 0, 0, 1); afterRise();
    chk("R4 xq dIn", xq, 1);
    ce = 0;
    drive(0, 0, 0, 0); afterRise();
    chk("R5 xq kept with ce low", xq, 1);
    chk("R5 yq kept with ce low", yq, 1);

    // Set/reset values and priority
    c.xSrVal = 1; c.ySrVal = 0;
    loadCfg(c);
    ce = 1; sr = 1;
    drive(0, 0, 0, 0); afterRise();
    chk("R6 xq set", xq, 1);
    chk("R6 yq cleared", yq, 0);
    ce = 0;
    drive(0, 0, 0, 1); afterRise();
    chk("R6 xq set with ce low", xq, 1);
    chk("R6 yq clear with ce low", yq, 0);
    ce = 1;
    drive(0, 0, 0, 1); afterRise();
    chk("R6 yq set value over data", yq, 0);
    sr = 0;
    drive(0, 0, 0, 0); afterRise();
    chk("R6 xq released", xq, 0);

    // Falling-edge mode
    c.xSrVal = 0; c.negEdge = 1;
    loadCfg(c);
    #(CLK_PERIOD/2 - 4); dIn = 1;
    afterRise();
    chk("R7 no update on rise", xq, 0);
    @(negedge clk); #1;
    chk("R7 update on fall", xq, 1);
    chk("R7 yq update on fall", yq, 1);
    #2 dIn = 0;
    afterRise();
    chk("R7 rise ignored", yq, 1);

    // Bit-serial adder: 11 + 6
    c = '0; c.gTable = 16'h9696; c.fTable = 16'hE800; c.xSel = 2'd1; c.ySel = 2'd0;
    loadCfg(c);
    ce = 1;
    sum = 5'd11 + 5'd6;
    for (int k = 0; k < 4; k++) begin
      logic a, b;
      a = 4'd11 >> k; b = 4'd6 >> k;
      drive({1'b0, xq, b, a}, {1'b1, xq, b, a}, 0, 0);
      #1;
      chk("R9 sum bit", yOut, sum[k]);
      afterRise();
    end
    chk("R9 carry out", xq, sum[4]);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule